// File: doc/BRIEF.md
# Block-Write Serial Configuration Slave

This block is a two-wire serial slave that owns a small configuration register file (21 bytes by default) and exposes every byte to the surrounding logic on a flat bus. A host reaches it only through whole-block transfers that always begin at register 0. A write transfer carries the device address, a command byte and a count byte, which are acknowledged and thrown away, and then data bytes that fill the registers in ascending order until the host ends the transfer. A read transfer returns the programmed readback limit first and then registers 0 up to that limit.

Two register pairs, at indices 11/12 and 13/14, are treated as units. The first byte of a pair is parked in a shadow register, and both bytes land together only when the second byte arrives in the same transfer. A pair left half-written when a stop or repeated start arrives is dropped. Register 7 is a fixed identity byte, and register 8 sets the readback limit and refuses a zero.

The serial lines are oversampled by the system clock. The slave never stretches the clock, so the host alone paces every byte and there is no back-pressure path. The configuration bus is a plain level output with no handshake.

Top module: `cfgi2c_slave`

## Requirements
- R1: Address byte 0xD2 (write) and 0xD3 (read) are acknowledged, and any other address byte is left unacknowledged with no effect on the registers.
- R2: In a write, the two bytes that follow the address are acknowledged and their values change no register.
- R3: The data bytes of a write land at registers 0, 1, 2, ... in order, and a stop after any whole byte keeps every byte written before it.
- R4: A read returns the value of register 8 first, then registers 0 through that value inclusive. Any position past the last register returns 0xFF.
- R5: Register 8 resets to 0x08, and a write of 0x00 to it is ignored.
- R6: Registers 11 and 12 change only together, as do 13 and 14, and only when both bytes of the pair arrive in one transfer. A half-written pair is discarded at stop or repeated start.
- R7: Register 7 always reads 0x9 in its upper nibble and the REVISION parameter in its lower nibble (0x93 by default), and writes to it are ignored.
- R8: Every written data byte is acknowledged, including bytes beyond the last register, which are discarded.
- R9: A host not-acknowledge on a read byte ends the transmission, and the slave releases SDA. The slave changes SDA only while SCL is low, except when it releases SDA at a start or stop.
- R10: A start condition at any point restarts address reception, and a stop returns the slave to idle.
- R11: After reset, SDA is released and every register reads 0x00 except registers 7 and 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe_o | output | 1 | High to pull SDA low (open-drain drive) |
| cfg_o | output | NUM_REGS*8 | Register file contents, register k in bits 8k+7:8k |

## Verification
The bench uses the default parameters: 21 registers, pairs at 11 and 13, a readback limit of 8 after reset, and two header bytes. With these values, writes of 23 data bytes run past the end of the file, and limits of 20 and 22 make reads cover the whole file and then run into the 0xFF padding. The stimulus table stops writes on either side of each pair boundary, so both the commit and the discard paths of the shadow registers are exercised.

// File: rtl/cfgi2c_pkg.sv
package cfgi2c_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_RX,
    ST_ACK_OUT,
    ST_TX,
    ST_ACK_IN,
    ST_ACK_WAIT
  } bus_state_t;

  function automatic logic [7:0] sat_inc(input logic [7:0] v);
    return (v == 8'hFF) ? v : v + 8'd1;
  endfunction

endpackage

// File: rtl/cfgi2c_line_sync.sv
module cfgi2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/cfgi2c_bus_fsm.sv
module cfgi2c_bus_fsm
  import cfgi2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_s,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic [7:0] rd_byte,
  output logic       wr_valid,
  output logic [7:0] wr_pos,
  output logic [7:0] wr_data,
  output logic [7:0] rd_pos,
  output logic       sda_oe
);
  bus_state_t state;
  logic [3:0] bitcnt;
  logic [7:0] shreg, txreg, byte_no;
  logic       rw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      bitcnt   <= '0;
      shreg    <= '0;
      txreg    <= '0;
      byte_no  <= '0;
      rw       <= 1'b0;
      wr_valid <= 1'b0;
      wr_pos   <= '0;
      wr_data  <= '0;
      rd_pos   <= '0;
      sda_oe   <= 1'b0;
    end else begin
      wr_valid <= 1'b0;
      if (start_det) begin
        state   <= ST_ADDR;
        bitcnt  <= '0;
        byte_no <= '0;
        rd_pos  <= '0;
        sda_oe  <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR, ST_RX: begin
            if (scl_rise) begin
              shreg  <= {shreg[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              bitcnt <= '0;
              if (state == ST_ADDR) begin
                if (shreg[7:1] == DEV_ADDR) begin
                  rw     <= shreg[0];
                  sda_oe <= 1'b1;
                  state  <= ST_ACK_OUT;
                end else begin
                  state <= ST_IDLE;
                end
              end else begin
                wr_valid <= 1'b1;
                wr_pos   <= byte_no;
                wr_data  <= shreg;
                byte_no  <= sat_inc(byte_no);
                sda_oe   <= 1'b1;
                state    <= ST_ACK_OUT;
              end
            end
          end
          ST_ACK_OUT: begin
            if (scl_fall) begin
              if (rw) begin
                sda_oe <= ~rd_byte[7];
                txreg  <= {rd_byte[6:0], 1'b0};
                bitcnt <= 4'd1;
                rd_pos <= sat_inc(rd_pos);
                state  <= ST_TX;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bitcnt == 4'd8) begin
                sda_oe <= 1'b0;
                bitcnt <= '0;
                state  <= ST_ACK_IN;
              end else begin
                sda_oe <= ~txreg[7];
                txreg  <= {txreg[6:0], 1'b0};
                bitcnt <= bitcnt + 4'd1;
              end
            end
          end
          ST_ACK_IN: begin
            if (scl_rise) state <= sda_s ? ST_IDLE : ST_ACK_WAIT;
          end
          ST_ACK_WAIT: begin
            if (scl_fall) begin
              sda_oe <= ~rd_byte[7];
              txreg  <= {rd_byte[6:0], 1'b0};
              bitcnt <= 4'd1;
              rd_pos <= sat_inc(rd_pos);
              state  <= ST_TX;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assert_stop_to_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det && !start_det |=> (state == ST_IDLE) && !sda_oe);

  assert_start_to_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> state == ST_ADDR);

  // R9: SDA drive moves only with SCL low unless a start or stop released it
  assert_sda_moves_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && !$past(start_det || stop_det)) |-> !$past(scl_s));
endmodule

// File: rtl/cfgi2c_regfile.sv
module cfgi2c_regfile #(
  parameter int         NUM_REGS  = 21,
  parameter int         HDR_BYTES = 2,
  parameter int         ID_IDX    = 7,
  parameter int         LIM_IDX   = 8,
  parameter logic [7:0] LIM_RST   = 8'h08,
  parameter logic [3:0] VENDOR    = 4'b1001,
  parameter logic [3:0] REVISION  = 4'h3,
  parameter int         SET_FIRST = 11,
  parameter int         NUM_SETS  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  xfer_end,
  input  logic                  wr_valid,
  input  logic [7:0]            wr_pos,
  input  logic [7:0]            wr_data,
  input  logic [7:0]            rd_pos,
  output logic [7:0]            rd_byte,
  output logic [NUM_REGS*8-1:0] cfg_o
);
  localparam int         IW      = $clog2(NUM_REGS);
  localparam logic [7:0] ID_BYTE = {VENDOR, REVISION};

  logic [7:0] regs   [NUM_REGS];
  logic [7:0] view   [NUM_REGS];
  logic [7:0] shadow [NUM_SETS];
  logic [NUM_SETS-1:0] pend, hit_lo, hit_hi;
  logic [7:0] idx, rk;
  logic       in_range;

  assign idx      = wr_pos - 8'(HDR_BYTES);
  assign in_range = wr_valid && (wr_pos >= 8'(HDR_BYTES)) && (idx < 8'(NUM_REGS));

  always_comb begin
    for (int s = 0; s < NUM_SETS; s++) begin
      hit_lo[s] = (idx == 8'(SET_FIRST + 2*s));
      hit_hi[s] = (idx == 8'(SET_FIRST + 2*s + 1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= (i == LIM_IDX) ? LIM_RST : 8'h00;
      for (int s = 0; s < NUM_SETS; s++) shadow[s] <= 8'h00;
      pend <= '0;
    end else begin
      if (xfer_end) pend <= '0;
      if (in_range) begin
        for (int s = 0; s < NUM_SETS; s++) begin
          if (hit_lo[s]) begin
            shadow[s] <= wr_data;
            pend[s]   <= 1'b1;
          end
          if (hit_hi[s]) begin
            if (pend[s]) begin
              regs[SET_FIRST + 2*s]     <= shadow[s];
              regs[SET_FIRST + 2*s + 1] <= wr_data;
            end
            pend[s] <= 1'b0;
          end
        end
        if (!(|hit_lo) && !(|hit_hi) && idx != 8'(ID_IDX) &&
            !(idx == 8'(LIM_IDX) && wr_data == 8'h00))
          regs[idx[IW-1:0]] <= wr_data;
      end
    end
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_view
    assign view[i]        = (i == ID_IDX) ? ID_BYTE : regs[i];
    assign cfg_o[i*8 +: 8] = view[i];
  end

  assign rk = rd_pos - 8'd1;
  always_comb begin
    if (rd_pos == 8'd0)                                rd_byte = regs[LIM_IDX];
    else if (rk <= regs[LIM_IDX] && rk < 8'(NUM_REGS)) rd_byte = view[rk[IW-1:0]];
    else                                               rd_byte = 8'hFF;
  end

  assert_limit_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    regs[LIM_IDX] != 8'h00);

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set_chk
    assert_pair_atomic_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(regs[SET_FIRST + 2*s]) |->
        $past(in_range && idx == 8'(SET_FIRST + 2*s + 1) && pend[s]));
  end
endmodule

// File: rtl/cfgi2c_slave.sv
module cfgi2c_slave #(
  parameter int         NUM_REGS  = 21,
  parameter logic [6:0] DEV_ADDR  = 7'h69,
  parameter logic [3:0] REVISION  = 4'h3,
  parameter int         SET_FIRST = 11,
  parameter int         NUM_SETS  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe_o,
  output logic [NUM_REGS*8-1:0] cfg_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic wr_valid;
  logic [7:0] wr_pos, wr_data, rd_pos, rd_byte;

  cfgi2c_line_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det));

  cfgi2c_bus_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .rd_byte(rd_byte), .wr_valid(wr_valid),
    .wr_pos(wr_pos), .wr_data(wr_data), .rd_pos(rd_pos), .sda_oe(sda_oe_o));

  cfgi2c_regfile #(
    .NUM_REGS(NUM_REGS), .REVISION(REVISION),
    .SET_FIRST(SET_FIRST), .NUM_SETS(NUM_SETS)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .xfer_end(start_det | stop_det),
    .wr_valid(wr_valid), .wr_pos(wr_pos), .wr_data(wr_data),
    .rd_pos(rd_pos), .rd_byte(rd_byte), .cfg_o(cfg_o));
endmodule

// File: tb/cfgi2c_slave_tb.sv
module cfgi2c_slave_tb_top;
  localparam int         NREG = 21;
  localparam int         Q    = 12;
  localparam logic [7:0] IDB  = 8'h93;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe, sda_line;
  logic [NREG*8-1:0] cfg;
  int checks = 0, fails = 0;
  logic [7:0] mdl [NREG];

  always #2.5 clk = ~clk;
  assign sda_line = m_sda & ~sda_oe;

  cfgi2c_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .cfg_o(cfg));

  // {data bytes, base value, value for register 8}
  localparam logic [23:0] VEC [6] = '{
    {8'd3,  8'h10, 8'h00},
    {8'd12, 8'h30, 8'h14},
    {8'd13, 8'h50, 8'h00},
    {8'd14, 8'h70, 8'h16},
    {8'd23, 8'h90, 8'h0C},
    {8'd0,  8'h00, 8'h00}
  };

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic qw; repeat (Q) @(negedge clk); endtask

  task automatic bus_start;
    m_sda = 1'b1; qw; m_scl = 1'b1; qw; m_sda = 1'b0; qw; m_scl = 1'b0; qw;
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; qw; m_scl = 1'b1; qw; m_sda = 1'b1; qw;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; qw; m_scl = 1'b1; qw; qw; m_scl = 1'b0; qw;
    end
    m_sda = 1'b1; qw; m_scl = 1'b1; qw; acked = !sda_line; qw; m_scl = 1'b0; qw;
  endtask

  task automatic recv_byte(input logic ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      qw; m_scl = 1'b1; qw; b[i] = sda_line; qw; m_scl = 1'b0;
    end
    m_sda = !ack; qw; m_scl = 1'b1; qw; qw; m_scl = 1'b0; qw; m_sda = 1'b1;
  endtask

  function automatic logic [7:0] exp_reg(input int k);
    if (k >= NREG) return 8'hFF;
    if (k == 7) return IDB;
    return mdl[k];
  endfunction

  task automatic check_cfg(input string tag);
    for (int k = 0; k < NREG; k++) chk(tag, cfg[k*8 +: 8], exp_reg(k));
  endtask

  task automatic block_write(input int n, input logic [7:0] base, input logic [7:0] c8);
    logic a;
    logic [7:0] d, pv;
    logic pend;
    pend = 1'b0; pv = 8'h00;
    bus_start;
    send_byte(8'hD2, a); chk("R1 write address ack", a, 1'b1);
    send_byte(8'hA5, a); chk("R2 command ack", a, 1'b1);
    send_byte(8'h5A, a); chk("R2 count ack", a, 1'b1);
    for (int i = 0; i < n; i++) begin
      d = (i == 8) ? c8 : base + 8'(i);
      send_byte(d, a); chk("R8 data ack", a, 1'b1);
      if (i < NREG && i != 7 && !(i == 8 && d == 8'h00)) begin
        if (i == 11 || i == 13) begin pend = 1'b1; pv = d; end
        else if (i == 12 || i == 14) begin
          if (pend) begin mdl[i-1] = pv; mdl[i] = d; end
          pend = 1'b0;
        end else mdl[i] = d;
      end
    end
    bus_stop;
  endtask

  task automatic block_read;
    logic a;
    logic [7:0] b;
    int lim;
    lim = mdl[8];
    bus_start;
    send_byte(8'hD3, a); chk("R1 read address ack", a, 1'b1);
    recv_byte(1'b1, b); chk("R4 count byte", b, mdl[8]);
    for (int k = 0; k <= lim; k++) begin
      recv_byte(k != lim, b);
      chk("R4 read byte", b, exp_reg(k));
    end
    chk("R9 released after nack", sda_oe, 1'b0);
    bus_stop;
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired: got hang expected completion");
    finish_run;
  end

  initial begin
    logic a;
    logic [7:0] b;
    for (int k = 0; k < NREG; k++) mdl[k] = 8'h00;
    mdl[8] = 8'h08;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R11 / R5 / R7: reset contents and released line
    chk("R11 sda released", sda_oe, 1'b0);
    check_cfg("R11 reset contents");
    chk("R5 limit reset", cfg[8*8 +: 8], 8'h08);
    chk("R7 identity", cfg[7*8 +: 8], IDB);

    // R1: foreign address is ignored
    bus_start;
    send_byte(8'hA0, a); chk("R1 foreign address nack", a, 1'b0);
    bus_stop;
    check_cfg("R1 foreign address no effect");

    // R3 R4 R5 R6 R7 R8: table of block writes, each followed by readback
    for (int v = 0; v < 6; v++) begin
      block_write(int'(VEC[v][23:16]), VEC[v][15:8], VEC[v][7:0]);
      check_cfg("R3 R6 R7 contents after write");
      block_read;
    end

    // R10: repeated start after a data byte, then read with early nack (R9)
    bus_start;
    send_byte(8'hD2, a); send_byte(8'h00, a); send_byte(8'h00, a);
    send_byte(8'hEE, a); chk("R8 ack before restart", a, 1'b1);
    mdl[0] = 8'hEE;
    send_byte(8'h11, a);
    bus_start;
    send_byte(8'hD3, a); chk("R10 address after restart", a, 1'b1);
    recv_byte(1'b1, b); chk("R10 count after restart", b, mdl[8]);
    recv_byte(1'b1, b); chk("R10 byte0 after restart", b, 8'hEE);
    recv_byte(1'b0, b); chk("R10 byte1 after restart", b, 8'h11);
    mdl[1] = 8'h11;
    chk("R9 release on early nack", sda_oe, 1'b0);
    bus_stop;
    check_cfg("R10 contents after restart");
    chk("R10 idle after stop", sda_oe, 1'b0);

    finish_run;
  end
endmodule